// File: doc/BRIEF.md
# Parallel EPROM Read Sequencer

This controller sits on the host side of a byte-wide, 1M x 8 UV-erasable EPROM. It turns a single-cycle host request into a timed asynchronous read cycle. The request carries either a 20-bit byte address or an identification-code read. For the duration of the cycle the block drives the address and the two active-low enables. It waits out the part's access time with cycle counters, captures the byte, hands it back with a one-cycle `ready` pulse, and then keeps the bus quiet long enough for the part to stop driving.

Timing comes from a clock-period parameter and a 2-bit speed grade that is latched when a request is accepted. Output-enable is dropped as late as the part allows, so that it never lengthens the read. An identification read replaces the elevated-voltage pin with a digital flag, `mem_id`. The host selects between the two identifier bytes with `id_byte`.

Top module: `eprom_rd_seq`

## Requirements
- R1: After reset `mem_ce_n` and `mem_oe_n` are 1, `ready` is 0 and `mem_id` is 0.
- R2: A normal read (`id_sel`=0) drives `addr` on `mem_addr` with `mem_id`=0, and returns the byte present on `mem_dq`. Address and flag stay stable while `mem_ce_n` is low.
- R3: `mem_oe_n` falls exactly L = floor((tACC - tOE) / CLK_PERIOD_NS) cycles after `mem_ce_n` falls.
- R4: `mem_dq` is captured N = ceil(tACC / CLK_PERIOD_NS) + 1 cycles after `mem_ce_n` falls. `ready` rises on that same edge, lasts exactly one cycle, and `rdata` then holds the byte.
- R5: `mem_ce_n` and `mem_oe_n` rise together on the capture edge.
- R6: After `mem_ce_n` rises, it cannot fall again sooner than F + 1 cycles, where F = ceil(tDF / CLK_PERIOD_NS) + 1. A request held during this gap waits, and is accepted exactly F + 1 cycles after the rise.
- R7: An identification read (`id_sel`=1) drives `mem_id`=1 with every `mem_addr` bit 0 except bit 0, which equals `id_byte` (0 = maker code, 1 = device code).
- R8: The grade encoding for tACC/tOE/tDF in ns is: 0 = 90/20/30, 1 = 100/20/30, 2 = 120/30/35, 3 = 150/35/40. `grade` is sampled only when a request is accepted, and changing it mid-read has no effect on that read.
- R9: `mem_oe_n` is never low while `mem_ce_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Read request, accepted when idle |
| addr | input | 20 | Byte address for a normal read |
| id_sel | input | 1 | 1 = identification read |
| id_byte | input | 1 | Identifier select (0 maker, 1 device) |
| grade | input | 2 | Speed grade |
| ready | output | 1 | One-cycle pulse, `rdata` valid |
| rdata | output | 8 | Captured byte |
| mem_addr | output | 20 | Memory address lines |
| mem_id | output | 1 | Identification-level flag for the ID pin |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq | input | 8 | Memory data lines |

## Verification
The bench's memory model returns the complement of the true byte until the address, chip-enable and output-enable times have all elapsed. A sequencer that samples one cycle early, or that drops output-enable too late, therefore returns wrong data. Each read measures the output-enable lead, the capture latency and the enable release against the accepted grade. The grade input is inverted in the middle of some reads, so a design that uses the live grade shows a wrong latency. Back-to-back requests measure the gap from release to the next chip-enable. A gap shorter than the float time, or one padded longer than needed, is reported.

// File: rtl/eprom_rd_seq.sv
module eprom_rd_seq #(
  parameter int CLK_PERIOD_NS = 10,
  parameter int AW = 20,
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [AW-1:0] addr,
  input  logic          id_sel,
  input  logic          id_byte,
  input  logic [1:0]    grade,
  output logic          ready,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_id,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  input  logic [DW-1:0] mem_dq
);
  localparam int P = CLK_PERIOD_NS;

  function automatic int t_acc(input logic [1:0] g);
    case (g) 2'd0: return 90; 2'd1: return 100; 2'd2: return 120; default: return 150; endcase
  endfunction
  function automatic int t_oe(input logic [1:0] g);
    case (g) 2'd0, 2'd1: return 20; 2'd2: return 30; default: return 35; endcase
  endfunction
  function automatic int t_df(input logic [1:0] g);
    case (g) 2'd0, 2'd1: return 30; 2'd2: return 35; default: return 40; endcase
  endfunction
  function automatic int n_lead(input logic [1:0] g);
    return (t_acc(g) - t_oe(g)) / P;
  endfunction
  function automatic int n_acc(input logic [1:0] g);
    return (t_acc(g) + P - 1) / P + 1;
  endfunction
  function automatic int n_flt(input logic [1:0] g);
    return (t_df(g) + P - 1) / P + 1;
  endfunction

  typedef enum logic [2:0] {IDLE, SETUP, OE_WAIT, SAMPLE, FLOAT} st_t;
  st_t st;
  logic [1:0]    g_q;
  logic [CW-1:0] cnt;
  wire           cnt_done = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; g_q <= '0; cnt <= '0;
      ready <= 1'b0; rdata <= '0;
      mem_addr <= '0; mem_id <= 1'b0;
      mem_ce_n <= 1'b1; mem_oe_n <= 1'b1;
    end else begin
      ready <= 1'b0;
      case (st)
        IDLE: if (req) begin
          g_q      <= grade;
          mem_addr <= id_sel ? {{(AW-1){1'b0}}, id_byte} : addr;
          mem_id   <= id_sel;
          mem_ce_n <= 1'b0;
          cnt      <= CW'(n_lead(grade) - 1);
          st       <= SETUP;
        end
        SETUP: if (cnt_done) begin
          mem_oe_n <= 1'b0;
          cnt      <= CW'(n_acc(g_q) - n_lead(g_q) - 2);
          st       <= OE_WAIT;
        end else cnt <= cnt - 1'b1;
        OE_WAIT: if (cnt_done) st <= SAMPLE;
                 else cnt <= cnt - 1'b1;
        SAMPLE: begin
          rdata    <= mem_dq;
          ready    <= 1'b1;
          mem_ce_n <= 1'b1;
          mem_oe_n <= 1'b1;
          mem_id   <= 1'b0;
          cnt      <= CW'(n_flt(g_q) - 1);
          st       <= FLOAT;
        end
        FLOAT: if (cnt_done) st <= IDLE;
               else cnt <= cnt - 1'b1;
        default: st <= IDLE;
      endcase
    end
  end

  logic [CW-1:0] gap_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_cnt <= '1;
    else if (!mem_ce_n) gap_cnt <= '0;
    else if (gap_cnt != '1) gap_cnt <= gap_cnt + 1'b1;
  end

  // R9
  oe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_ce_n |-> mem_oe_n);
  // R4
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) ready |=> !ready);
  // R5
  release_together_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_ce_n) |-> $rose(mem_oe_n));
  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_id)));
  // R7
  id_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_id && !mem_ce_n) |-> (mem_addr[AW-1:1] == '0));
  // R6
  float_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> ($past(gap_cnt) >= CW'(n_flt($past(g_q)))));
endmodule

// File: tb/eprom_rd_seq_test.sv
`timescale 1ns/1ps
module eprom_rd_seq_test;
  localparam int P = 10;
  localparam logic [7:0] MFR = 8'hB7, DEV = 8'h6D;

  logic clk = 0, rst_n = 0, req = 0, id_sel = 0, id_byte = 0;
  logic [19:0] addr = '0;
  logic [1:0] grade = '0;
  logic ready, mem_id, mem_ce_n, mem_oe_n;
  logic [7:0] rdata, mem_dq;
  logic [19:0] mem_addr;

  always #5 clk = ~clk;

  eprom_rd_seq uut (.clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .id_sel(id_sel),
    .id_byte(id_byte), .grade(grade), .ready(ready), .rdata(rdata), .mem_addr(mem_addr),
    .mem_id(mem_id), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_dq(mem_dq));

  int n_chk = 0, n_fail = 0;
  bit b2b = 0;
  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin n_fail++; $display("FAIL %s: actual %0d expected %0d", r, act, exp); end
  endtask

  function automatic int tacc(input logic [1:0] g); return g == 0 ? 90 : g == 1 ? 100 : g == 2 ? 120 : 150; endfunction
  function automatic int toe(input logic [1:0] g);  return g <= 1 ? 20 : g == 2 ? 30 : 35; endfunction
  function automatic int tdf(input logic [1:0] g);  return g <= 1 ? 30 : g == 2 ? 35 : 40; endfunction
  function automatic int exp_l(input logic [1:0] g); return (tacc(g) - toe(g)) / P; endfunction
  function automatic int exp_n(input logic [1:0] g); return (tacc(g) + P - 1) / P + 1; endfunction
  function automatic int exp_f(input logic [1:0] g); return (tdf(g) + P - 1) / P + 1; endfunction
  function automatic logic [7:0] hb(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h5A;
  endfunction

  // memory model: complement of true byte until all access times have elapsed
  logic [1:0] mg = '0;
  realtime t_ce = 0, t_oe = 0, t_ad = 0;
  always @(negedge mem_ce_n) t_ce = $realtime;
  always @(negedge mem_oe_n) t_oe = $realtime;
  always @(mem_addr or mem_id) t_ad = $realtime;
  always begin
    #1;
    begin
      logic [7:0] b;
      realtime now;
      now = $realtime;
      b = mem_id ? (mem_addr[19:1] == '0 ? (mem_addr[0] ? DEV : MFR) : 8'hEE) : hb(mem_addr);
      if (!mem_ce_n && !mem_oe_n && now - t_ce >= tacc(mg) && now - t_ad >= tacc(mg)
          && now - t_oe >= toe(mg))
        mem_dq = b;
      else
        mem_dq = ~b;
    end
  end

  typedef struct { logic [19:0] ma; bit id; logic [7:0] d; logic [1:0] g; } item_t;
  item_t q[$];

  task automatic rd(input logic [19:0] a, input bit id, input bit idb, input logic [1:0] g, input bit flip);
    item_t it;
    it.ma = id ? {19'd0, idb} : a;
    it.id = id;
    it.d  = id ? (idb ? DEV : MFR) : hb(a);
    it.g  = g;
    q.push_back(it);
    addr = a; id_sel = id; id_byte = idb; grade = g; mg = g; req = 1;
    do @(negedge clk); while (mem_ce_n);
    req = 0;
    if (flip) grade = ~g;
    do @(negedge clk); while (!ready);
  endtask

  // monitor
  int cyc = 0, cefall = 0, cerise = -100, lastf = 0;
  bit pce = 1, poe = 1, pready = 0, have_rise = 0;
  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (pready) chk(!ready, "R4 ready width", ready, 0);
    if (pce && !mem_ce_n) begin
      cefall = cyc;
      if (have_rise) begin
        if (b2b) chk(cyc - cerise == lastf + 1, "R6 gap exact", cyc - cerise, lastf + 1);
        else     chk(cyc - cerise >= lastf + 1, "R6 gap min", cyc - cerise, lastf + 1);
      end
    end
    if (poe && !mem_oe_n && q.size() > 0) begin
      chk(cyc - cefall == exp_l(q[0].g), "R3 oe lead", cyc - cefall, exp_l(q[0].g));
      chk(!mem_ce_n, "R9 oe with ce", mem_ce_n, 0);
      if (q[0].id) chk(mem_id && mem_addr == q[0].ma, "R7 id addr", mem_addr, q[0].ma);
      else         chk(!mem_id && mem_addr == q[0].ma, "R2 addr", mem_addr, q[0].ma);
    end
    if (!pce && mem_ce_n) begin
      cerise = cyc; have_rise = 1;
      chk(mem_oe_n && !poe, "R5 release", mem_oe_n, 1);
    end
    if (ready && !pready) begin
      if (q.size() == 0) chk(0, "R4 spurious ready", 1, 0);
      else begin
        item_t it;
        it = q.pop_front();
        chk(cyc - cefall == exp_n(it.g), "R4/R8 latency", cyc - cefall, exp_n(it.g));
        chk(rdata == it.d, it.id ? "R7 id data" : "R2 data", rdata, it.d);
        lastf = exp_f(it.g);
      end
    end
    pce = mem_ce_n; poe = mem_oe_n; pready = ready;
  end

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_ce_n === 1'b1, "R1 ce", mem_ce_n, 1);
    chk(mem_oe_n === 1'b1, "R1 oe", mem_oe_n, 1);
    chk(ready === 1'b0, "R1 ready", ready, 0);
    chk(mem_id === 1'b0, "R1 id", mem_id, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R2 normal reads across address corners, grade 0
    rd(20'h00000, 0, 0, 2'd0, 0);
    rd(20'hFFFFF, 0, 0, 2'd0, 0);
    rd(20'h12345, 0, 0, 2'd0, 0);
    repeat (4) @(negedge clk);
    // R7 both identifier bytes, grade 1
    rd(20'hABCDE, 1, 0, 2'd1, 0);
    rd(20'h54321, 1, 1, 2'd1, 0);
    repeat (4) @(negedge clk);
    // R8 grades 2 and 3, grade input flipped mid-read
    rd(20'h0F0F0, 0, 0, 2'd2, 1);
    rd(20'hA5A5A, 0, 0, 2'd3, 1);
    rd(20'h00001, 1, 1, 2'd3, 1);
    repeat (4) @(negedge clk);
    // R6 back-to-back: request waits through the float gap
    b2b = 1;
    rd(20'h80000, 0, 0, 2'd0, 0);
    rd(20'h7FFFF, 0, 0, 2'd3, 0);
    rd(20'h00200, 0, 0, 2'd2, 0);
    rd(20'h00200, 1, 0, 2'd1, 0);
    rd(20'h3C3C3, 0, 0, 2'd0, 0);
    b2b = 0;
    repeat (10) @(negedge clk);
    chk(q.size() == 0, "R4 all returned", q.size(), 0);
    chk(mem_ce_n && mem_oe_n, "R5 idle enables", {mem_ce_n, mem_oe_n}, 3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule